// File: doc/BRIEF.md
# Cascaded Prescaler Watchdog Timer

This unit combines a periodic interval timer with a watchdog. It is clocked by a slow always-on clock. A first prescaler divides that clock by a programmable power of two. Each of its ticks advances a 16-bit reloading down-counter, which emits a one-cycle event pulse every time it wraps. A second power-of-two prescaler feeds the 8-bit watchdog down-counter. Its input is either the first prescaler's tick or the raw clock. When the watchdog runs out it emits a one-cycle reset pulse and sets a sticky status flag.

Software reaches the unit through eight byte-wide registers. The configuration register holds the feed enable, the watchdog source select and four sticky lock bits. There are two prescaler exponents, the timer reload value split into two bytes, and the watchdog preset. A control/status register holds a self-clearing timer reload request, a write-1-to-clear watchdog flag, a stored early-touch disable bit and a read-only run bit. A write-only service register accepts key bytes. One key feeds the watchdog. A fixed three-byte sequence stops it.

The watchdog runs from reset with a preset of 255 raw-clock ticks. Feeding also restarts a stopped watchdog.

Top module: `wdog_cascade`

## Requirements
- R1: After reset the register reads are as follows. Configuration (address 0) reads 0x00. The timer exponent (1), watchdog exponent (2) and both reload bytes (3 low, 4 high) read 0. The watchdog preset (5) reads 0xFF. Control/status (6) reads 0x08, which is run=1.
- R2: With timer exponent e and reload value R, `tmr_evt` pulses for one cycle every (R+1)·2^e clock cycles.
- R3: Writing 1 to control/status bit 0 requests a timer reload. The request reads back 0 once the hardware has loaded the counter, one cycle later. The timer then restarts from R with a cleared prescaler.
- R4: Configuration bit 4 selects the watchdog prescaler input: 1 selects the timer prescaler tick, 0 selects the raw clock. With preset N, watchdog exponent w and bit 4 set, `wd_rst` pulses every N·2^w·2^e cycles.
- R5: A watchdog preset of 0 gives the maximum interval of 256 watchdog ticks.
- R6: Writing 0x5C to the service register (address 7) with configuration bit 5 set reloads the counter from the preset, restarts the watchdog prescaler and sets run. With bit 5 clear the byte has no effect.
- R7: Writing 0x87, then 0x61, then 0x63 to the service register stops the watchdog. Run (control/status bit 3) then reads 0 and no `wd_rst` pulse follows.
- R8: A byte out of order aborts the stop sequence. An incomplete or broken sequence leaves the watchdog running with its period unchanged.
- R9: Each `wd_rst` pulse sets control/status bit 1. Writing 1 there clears it, and writing 0 leaves it unchanged.
- R10: Configuration bits 0 to 3 lock, respectively, the configuration register, both prescaler exponents, both reload bytes and the watchdog preset. A lock bit can only be set, and it stays set until reset. Writes to a locked register are ignored.
- R11: Control/status bit 2 (early-touch disable) is a plain read/write storage bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tmr_evt | output | 1 | One-cycle periodic timer event |
| wd_rst | output | 1 | One-cycle watchdog expiry pulse |

## Verification
A corrupted timer or watchdog count shows at the ports as a wrong spacing between event or reset pulses. The error is visible within one full period, so the bench measures pulse-to-pulse intervals in clock cycles. A stop-sequence recogniser in the wrong state shows up either as a run bit that clears without a complete sequence, or as reset pulses that keep arriving after a complete one; the run bit reveals it on the next status read. A lost lock or flag bit is exposed on the next register read, one cycle after the offending write.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int RLD_W = 16;
  localparam int WD_W  = 8;

  typedef enum logic [2:0] {
    A_CFG  = 3'd0,
    A_TPRE = 3'd1,
    A_WPRE = 3'd2,
    A_RLO  = 3'd3,
    A_RHI  = 3'd4,
    A_WCNT = 3'd5,
    A_CSR  = 3'd6,
    A_SVC  = 3'd7
  } addr_e;

  localparam logic [7:0] FEED_KEY = 8'h5C;
  localparam logic [7:0] STOP_K1  = 8'h87;
  localparam logic [7:0] STOP_K2  = 8'h61;
  localparam logic [7:0] STOP_K3  = 8'h63;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ONE  = 2'd1,
    SQ_TWO  = 2'd2
  } stop_st_e;
endpackage

// File: rtl/wdc_prescaler.sv
module wdc_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [EXP_W-1:0] ratio_log2,
  output logic             tick
);
  localparam int CNT_W = (1 << EXP_W) - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    mask = (ONE << ratio_log2) - ONE;
    tick = en && !clr && ((cnt_q & mask) == mask);
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdc_timer.sv
module wdc_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] reload_val,
  output logic         evt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         evt_q, evt_d;

  always_comb begin
    cnt_d = cnt_q;
    evt_d = 1'b0;
    if (load) begin
      cnt_d = reload_val;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_d = reload_val;
        evt_d = 1'b1;
      end else begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      evt_q <= evt_d;
    end
  end

  assign evt = evt_q;

  // R2
  evt_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(tick));
endmodule

// File: rtl/wdc_dog.sv
module wdc_dog
  import wdc_pkg::*;
#(
  parameter int CW = 8,
  parameter logic [CW-1:0] RST_CNT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          svc_wr,
  input  logic [7:0]    svc_byte,
  input  logic          feed_en,
  input  logic [CW-1:0] preset,
  output logic          run,
  output logic          fire,
  output logic          feed
);
  stop_st_e      seq_q, seq_d;
  logic          run_q, run_d, fire_q, fire_d, stop_hit, feed_hit;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    seq_d    = seq_q;
    stop_hit = 1'b0;
    feed_hit = 1'b0;
    if (svc_wr) begin
      if (svc_byte == STOP_K1)                         seq_d = SQ_ONE;
      else if (seq_q == SQ_ONE && svc_byte == STOP_K2) seq_d = SQ_TWO;
      else if (seq_q == SQ_TWO && svc_byte == STOP_K3) begin
        seq_d    = SQ_IDLE;
        stop_hit = 1'b1;
      end else                                          seq_d = SQ_IDLE;
      feed_hit = feed_en && (svc_byte == FEED_KEY);
    end
  end

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (stop_hit) begin
      run_d = 1'b0;
    end else if (feed_hit) begin
      run_d = 1'b1;
      cnt_d = preset;
    end else if (tick && run_q) begin
      if (cnt_q == CW'(1)) begin
        fire_d = 1'b1;
        cnt_d  = preset;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      run_q  <= 1'b1;
      cnt_q  <= RST_CNT;
      fire_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign run  = run_q;
  assign fire = fire_q;
  assign feed = feed_hit;

  // R7
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !run_q);
  // R6
  feed_loads_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_hit |=> (run_q && cnt_q == $past(preset)));
  // R7
  no_fire_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(run_q));
endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade
  import wdc_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter logic [WD_W-1:0] WD_RST_CNT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tmr_evt,
  output logic       wd_rst
);
  localparam int PAD_W = 8 - EXP_W;

  logic             feed_en_q, feed_en_d, wsrc_q, wsrc_d;
  logic [3:0]       lock_q, lock_d;
  logic [EXP_W-1:0] tpre_q, tpre_d, wpre_q, wpre_d;
  logic [RLD_W-1:0] rel_q, rel_d;
  logic [WD_W-1:0]  wpreset_q, wpreset_d;
  logic             reload_q, reload_d, flag_q, flag_d, etd_q, etd_d;
  logic             wr_csr, rl_set, svc_wr;
  logic             t_tick, w_en, w_tick, dog_run, dog_fire, dog_feed;

  always_comb begin
    feed_en_d = feed_en_q;
    wsrc_d    = wsrc_q;
    lock_d    = lock_q;
    tpre_d    = tpre_q;
    wpre_d    = wpre_q;
    rel_d     = rel_q;
    wpreset_d = wpreset_q;
    etd_d     = etd_q;
    wr_csr    = reg_wr && (reg_addr == A_CSR);
    rl_set    = wr_csr && reg_wdata[0];
    svc_wr    = reg_wr && (reg_addr == A_SVC);
    if (reg_wr) begin
      case (reg_addr)
        A_CFG: if (!lock_q[0]) begin
          feed_en_d = reg_wdata[5];
          wsrc_d    = reg_wdata[4];
          lock_d    = lock_q | reg_wdata[3:0];
        end
        A_TPRE: if (!lock_q[1]) tpre_d = reg_wdata[EXP_W-1:0];
        A_WPRE: if (!lock_q[1]) wpre_d = reg_wdata[EXP_W-1:0];
        A_RLO:  if (!lock_q[2]) rel_d[7:0]  = reg_wdata;
        A_RHI:  if (!lock_q[2]) rel_d[15:8] = reg_wdata;
        A_WCNT: if (!lock_q[3]) wpreset_d = reg_wdata;
        A_CSR:  etd_d = reg_wdata[2];
        default: ;
      endcase
    end
    reload_d = rl_set;
    flag_d   = flag_q;
    if (dog_fire)                       flag_d = 1'b1;
    else if (wr_csr && reg_wdata[1])    flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feed_en_q <= 1'b0;
      wsrc_q    <= 1'b0;
      lock_q    <= '0;
      tpre_q    <= '0;
      wpre_q    <= '0;
      rel_q     <= '0;
      wpreset_q <= WD_RST_CNT;
      reload_q  <= 1'b0;
      flag_q    <= 1'b0;
      etd_q     <= 1'b0;
    end else begin
      feed_en_q <= feed_en_d;
      wsrc_q    <= wsrc_d;
      lock_q    <= lock_d;
      tpre_q    <= tpre_d;
      wpre_q    <= wpre_d;
      rel_q     <= rel_d;
      wpreset_q <= wpreset_d;
      reload_q  <= reload_d;
      flag_q    <= flag_d;
      etd_q     <= etd_d;
    end
  end

  wdc_prescaler #(.EXP_W(EXP_W)) u_tpre (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .clr(reload_q),
    .ratio_log2(tpre_q), .tick(t_tick)
  );

  wdc_timer #(.W(RLD_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(t_tick), .load(reload_q),
    .reload_val(rel_q), .evt(tmr_evt)
  );

  assign w_en = wsrc_q ? t_tick : 1'b1;

  wdc_prescaler #(.EXP_W(EXP_W)) u_wpre (
    .clk(clk), .rst_n(rst_n), .en(w_en), .clr(dog_feed),
    .ratio_log2(wpre_q), .tick(w_tick)
  );

  wdc_dog #(.CW(WD_W), .RST_CNT(WD_RST_CNT)) u_dog (
    .clk(clk), .rst_n(rst_n), .tick(w_tick), .svc_wr(svc_wr),
    .svc_byte(reg_wdata), .feed_en(feed_en_q), .preset(wpreset_q),
    .run(dog_run), .fire(dog_fire), .feed(dog_feed)
  );

  assign wd_rst = dog_fire;

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {2'b00, feed_en_q, wsrc_q, lock_q};
      A_TPRE:  reg_rdata = {{PAD_W{1'b0}}, tpre_q};
      A_WPRE:  reg_rdata = {{PAD_W{1'b0}}, wpre_q};
      A_RLO:   reg_rdata = rel_q[7:0];
      A_RHI:   reg_rdata = rel_q[15:8];
      A_WCNT:  reg_rdata = wpreset_q;
      A_CSR:   reg_rdata = {4'b0000, dog_run, etd_q, flag_q, reload_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  // R3
  reload_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q && !rl_set) |=> !reload_q);
  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_q & $past(lock_q)) == $past(lock_q)));
  // R9
  flag_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dog_fire |=> flag_q);
endmodule

// File: tb/wdog_cascade_bench.sv
module wdog_cascade_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tmr_evt, wd_rst;
  logic       probe = 1'b0;

  typedef struct {
    int    kind;
    int    val;
    int    id;
    string tag;
  } item_t;

  item_t exp_q[$];
  int    n_cmp = 0, n_bad = 0, next_id = 1, cur_id = 0;
  int    cyc = 0, prev = 0, wd_cnt = 0;
  bit    have_prev = 0;

  always #2 clk = ~clk;

  wdog_cascade u_wdog_cascade (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tmr_evt(tmr_evt), .wd_rst(wd_rst)
  );

  // monitor: pops expected items and compares against observed results
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (wd_rst) wd_cnt = wd_cnt + 1;
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q[0];
      if (it.id != cur_id) begin
        cur_id = it.id;
        have_prev = 0;
      end
      if (it.kind == 0 && probe) begin
        n_cmp++;
        if (reg_rdata != it.val[7:0]) begin
          n_bad++;
          $display("FAIL %s: read got 0x%02h expected 0x%02h", it.tag, reg_rdata, it.val[7:0]);
        end
        void'(exp_q.pop_front());
      end else if ((it.kind == 1 && tmr_evt) || (it.kind == 2 && wd_rst)) begin
        if (have_prev) begin
          n_cmp++;
          if (cyc - prev != it.val) begin
            n_bad++;
            $display("FAIL %s: period got %0d expected %0d", it.tag, cyc - prev, it.val);
          end
          void'(exp_q.pop_front());
        end else begin
          prev = cyc;
          have_prev = 1;
        end
      end
    end
  end

  task automatic push(input int kind, input int val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.id = next_id; it.tag = tag;
    next_id++;
    exp_q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int e, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    push(0, e, tag);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
    wait (exp_q.size() == 0);
  endtask

  task automatic per_chk(input int kind, input int e, input string tag);
    push(kind, e, tag);
    wait (exp_q.size() == 0);
  endtask

  task automatic direct(input string tag, input int act, input int e);
    n_cmp++;
    if (act != e) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, e);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int snap;
    wait_cyc(5); #1 rst_n = 1'b1;
    // R1 reset state
    rd_chk(3'd0, 8'h00, "R1 cfg");
    rd_chk(3'd6, 8'h08, "R1 csr");
    rd_chk(3'd5, 8'hFF, "R1 wcnt");
    rd_chk(3'd1, 8'h00, "R1 tpre");
    rd_chk(3'd3, 8'h00, "R1 rlo");
    // R7 full stop sequence
    wr(3'd7, 8'h87); wr(3'd7, 8'h61); wr(3'd7, 8'h63);
    rd_chk(3'd6, 8'h00, "R7 run cleared");
    snap = wd_cnt; wait_cyc(600);
    direct("R7 no pulse after stop", wd_cnt - snap, 0);
    // R6 feed ignored when disabled
    wr(3'd7, 8'h5C);
    rd_chk(3'd6, 8'h00, "R6 feed disabled");
    // R5 preset 0 gives 256 ticks
    wr(3'd0, 8'h20); wr(3'd5, 8'h00); wr(3'd2, 8'h00); wr(3'd7, 8'h5C);
    per_chk(2, 256, "R5 max interval");
    // R9 flag behaviour
    rd_chk(3'd6, 8'h0A, "R9 flag set");
    wr(3'd6, 8'h00);
    rd_chk(3'd6, 8'h0A, "R9 write0 no effect");
    wr(3'd7, 8'h87); wr(3'd7, 8'h61); wr(3'd7, 8'h63);
    wr(3'd6, 8'h02);
    rd_chk(3'd6, 8'h00, "R9 w1c");
    // R11 storage bit
    wr(3'd6, 8'h04);
    rd_chk(3'd6, 8'h04, "R11 etd set");
    wr(3'd6, 8'h00);
    rd_chk(3'd6, 8'h00, "R11 etd clear");
    // R8 broken sequences
    wr(3'd5, 8'h04); wr(3'd2, 8'h01); wr(3'd7, 8'h5C);
    per_chk(2, 8, "R6 feed restart period");
    wr(3'd7, 8'h87); wr(3'd7, 8'h61); wr(3'd7, 8'h00); wr(3'd7, 8'h63);
    rd_chk(3'd6, 8'h0A, "R8 aborted third");
    per_chk(2, 8, "R8 period kept");
    wr(3'd7, 8'h87); wr(3'd7, 8'h00); wr(3'd7, 8'h61); wr(3'd7, 8'h63);
    rd_chk(3'd6, 8'h0A, "R8 aborted second");
    // R6 feeding holds off expiry
    wr(3'd5, 8'h14); wr(3'd2, 8'h00); wr(3'd7, 8'h5C);
    snap = wd_cnt;
    for (int i = 0; i < 20; i++) begin
      wr(3'd7, 8'h5C);
      wait_cyc(3);
    end
    direct("R6 fed dog silent", wd_cnt - snap, 0);
    // R2/R3 timer period and reload
    wr(3'd1, 8'h02); wr(3'd3, 8'h05); wr(3'd4, 8'h00); wr(3'd6, 8'h01);
    wait_cyc(3);
    rd_chk(3'd6, 8'h0A, "R3 reload self clear");
    per_chk(1, 24, "R2 timer period e2 r5");
    // R4 cascade
    wr(3'd0, 8'h30); wr(3'd2, 8'h01); wr(3'd5, 8'h05); wr(3'd7, 8'h5C);
    per_chk(2, 40, "R4 cascade period");
    wr(3'd1, 8'h00); wr(3'd3, 8'h02); wr(3'd6, 8'h01);
    per_chk(1, 3, "R2 timer period e0 r2");
    // R10 locks
    wr(3'd4, 8'h12); wr(3'd0, 8'h34); wr(3'd4, 8'h56);
    rd_chk(3'd4, 8'h12, "R10 reload locked");
    wr(3'd0, 8'h30);
    rd_chk(3'd0, 8'h34, "R10 lock sticky");
    wr(3'd0, 8'h3A); wr(3'd5, 8'h77); wr(3'd1, 8'h07);
    rd_chk(3'd5, 8'h05, "R10 preset locked");
    rd_chk(3'd1, 8'h00, "R10 prescaler locked");
    wr(3'd0, 8'h3F); wr(3'd0, 8'h00);
    rd_chk(3'd0, 8'h3F, "R10 cfg locked");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule